// File: doc/BRIEF.md
# 64B/66B Transmit Block Encoder

This block turns the transmit side of a 10 Gb/s Ethernet physical coding layer from characters into blocks. Every clock a transmit FIFO hands it one 64-bit word, eight byte lanes wide, together with one control flag per lane. The block classifies the word and packs it into a 66-bit block: a 2-bit sync header and a 64-bit payload. The result appears one clock later with a valid strobe. Scrambling and serialization are done downstream.

A transmit sequencing machine watches the class of each word: control, start, data, terminate or illegal. Whenever a word cannot legally follow its predecessor, or cannot be coded at all, it replaces that word with an error block. While reset is held, the output carries a local-fault ordered-set block on every cycle, so the far end learns that the local side is not ready.

Lane j occupies `in_data[8j+7:8j]` and `in_ctl[j]`. A lane with its control flag set carries one of five control characters: idle 0x07, start 0xFB, terminate 0xFD, error 0xFE or sequence 0x9C. Any other byte with the flag set is not codable.

Top module: `enc66_tx_encoder`

## Requirements
- R1: A word with all eight control flags clear yields sync header 2'b01, and its payload equals the input word bit for bit: lane j sits at payload bits 8j+7:8j. With the default header placement the header is `out_blk[1:0]` and the payload is `out_blk[65:2]`.
- R2: Every block containing a control character carries sync header 2'b10. A valid output never shows header 2'b00 or 2'b11.
- R3: A word whose eight lanes are all idle or error characters becomes type byte 0x1E in payload bits 7:0. Lane j then holds a 7-bit code at payload bit 8+7j: 0x00 for idle and 0x1E for error.
- R4: A start in lane 0 followed by seven data lanes becomes type 0x78, with lanes 1..7 at payload bits 63:8. Idle or error in lanes 0..3, start in lane 4 and data in lanes 5..7 becomes type 0x33. In that case the lane 0..3 codes sit at bit 8+7j, payload bits 39:36 are zero, and lanes 5..7 sit at payload bits 63:40.
- R5: A terminate in lane k, with data below it and idle or error above it, becomes type 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for k = 0..7. Data lane j<k sits at payload bit 8+8j, control lane j>k sits as a 7-bit code at bit 8+7j, and the remaining bits are zero.
- R6: A sequence character in lane 0, with data in lanes 1..3 and idle or error in lanes 4..7, becomes type 0x4B. Lanes 1..3 go to payload bits 31:8, bits 35:32 are zero, and the lane 4..7 codes sit at bit 8+7j.
- R7: While `rst_n` is low, from the first clock edge onward, the output is the local-fault block on every cycle with `out_vld` high. This block has header 2'b10, type 0x4B, payload bytes 1, 2 and 3 equal to 0x00, 0x00 and 0x01, and all other bits zero.
- R8: An error block is output in place of the word when sequencing is broken. The error block has header 2'b10, type 0x1E and all eight codes 0x1E. After reset, or after a control or terminate word, only a control or start word is legal. After a start or data word, only a data or terminate word is legal. A word of no codable form is always illegal.
- R9: An accepted word (`in_vld` high) appears at the output exactly one clock later with `out_vld` high. A cycle with `in_vld` low gives `out_vld` low on the next cycle, leaves the output block unchanged and leaves the sequencing state untouched.
- R10: After an error, a control, data or terminate word is coded normally and resumes the matching state. A start word keeps producing error blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; while low the output carries local-fault blocks |
| in_vld | input | 1 | Word on `in_data`/`in_ctl` is accepted this cycle |
| in_data | input | 64 | Eight byte lanes, lane 0 in bits 7:0 |
| in_ctl | input | 8 | Per-lane control flag, bit j for lane j |
| out_vld | output | 1 | `out_blk` holds a new block this cycle |
| out_blk | output | 66 | Encoded block, sync header in bits 1:0 by default |

## Verification
The bound assertions check, on every cycle, the properties that need no block decoding. These are: the header is always legal; reset forces the local-fault block; the one-cycle valid relation and output hold hold; data blocks come only from all-data words; a data word in the control state, or an idle word in the data state, produces an error block; and a data word leaves the error state. The exact payload layouts and type bytes are shown only by the bench's scenarios. These include every terminate lane, both start positions, ordered sets, error characters inside control blocks, and long constrained-random frame streams with injected illegal words, each compared against a bench model of the coding and sequencing rules.

// File: rtl/enc66_pkg.sv
package enc66_pkg;

   // control characters on the byte interface
   localparam logic [7:0] K_IDLE  = 8'h07;
   localparam logic [7:0] K_START = 8'hFB;
   localparam logic [7:0] K_TERM  = 8'hFD;
   localparam logic [7:0] K_ERR   = 8'hFE;
   localparam logic [7:0] K_SEQ   = 8'h9C;

   // 7-bit codes inside a block
   localparam logic [6:0] C7_IDLE = 7'h00;
   localparam logic [6:0] C7_ERR  = 7'h1E;

   // block type bytes
   localparam logic [7:0] BT_CTRL = 8'h1E;
   localparam logic [7:0] BT_S0   = 8'h78;
   localparam logic [7:0] BT_S4   = 8'h33;
   localparam logic [7:0] BT_OS0  = 8'h4B;

   // sync headers
   localparam logic [1:0] SH_DATA = 2'b01;
   localparam logic [1:0] SH_CTRL = 2'b10;

   typedef enum logic [2:0] {BK_C, BK_S, BK_D, BK_T, BK_E} blk_cls_e;

   typedef enum logic [2:0] {
      TS_INIT, TS_CTRL, TS_START, TS_DATA, TS_TERM, TS_ERR
   } tx_st_e;

   typedef struct packed {
      logic       dat;
      logic       idle;
      logic       err;
      logic       start;
      logic       term;
      logic       seq;
      logic [6:0] code;
   } lane_cls_t;

   function automatic logic [7:0] term_type(input logic [2:0] k);
      case (k)
         3'd0:    return 8'h87;
         3'd1:    return 8'h99;
         3'd2:    return 8'hAA;
         3'd3:    return 8'hB4;
         3'd4:    return 8'hCC;
         3'd5:    return 8'hD2;
         3'd6:    return 8'hE1;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [63:0] lf_payload();
      return {32'h0, 8'h01, 8'h00, 8'h00, BT_OS0};
   endfunction

   function automatic logic [63:0] err_payload();
      return {{8{C7_ERR}}, BT_CTRL};
   endfunction

   function automatic logic [65:0] pack_blk(input logic [1:0] sh,
                                            input logic [63:0] pay,
                                            input bit hdr_lsb);
      return hdr_lsb ? {pay, sh} : {sh, pay};
   endfunction

endpackage

// File: rtl/enc66_lane_cls.sv
module enc66_lane_cls
   import enc66_pkg::*;
#(
   parameter int unsigned CH_W = 8
)(
   input  logic [CH_W-1:0] ch,
   input  logic            ctl,
   output lane_cls_t       cls
);

   if (CH_W != 8) begin : g_bad_width
      $error("enc66_lane_cls: lanes must be 8 bits wide");
   end

   always_comb begin
      cls       = '0;
      cls.dat   = !ctl;
      cls.idle  = ctl && (ch == K_IDLE);
      cls.err   = ctl && (ch == K_ERR);
      cls.start = ctl && (ch == K_START);
      cls.term  = ctl && (ch == K_TERM);
      cls.seq   = ctl && (ch == K_SEQ);
      cls.code  = cls.err ? C7_ERR : C7_IDLE;
   end

endmodule

// File: rtl/enc66_blk_build.sv
module enc66_blk_build
   import enc66_pkg::*;
#(
   parameter int unsigned LANES = 8,
   parameter int unsigned CH_W  = 8
)(
   input  lane_cls_t [LANES-1:0]   lc,
   input  logic [LANES*CH_W-1:0]   data,
   output blk_cls_e                cls,
   output logic [1:0]              sh,
   output logic [LANES*CH_W-1:0]   pay
);

   localparam int unsigned DATA_W = LANES * CH_W;
   localparam int unsigned HALF   = LANES / 2;
   localparam int unsigned CODE_W = 7;
   localparam int unsigned LIDX_W = $clog2(LANES);

   logic [LANES-1:0]             dat, cc, tv;
   logic [LANES-1:0][CODE_W-1:0] code;
   logic [LANES-1:0]             lo_mask, hi_mask;
   logic [LIDX_W-1:0]            t_lane;
   logic                         all_dat, all_cc, os0_ok, s0_ok, s4_ok, t_ok;

   always_comb begin
      t_lane = '0;
      for (int j = 0; j < LANES; j++) begin
         dat[j]  = lc[j].dat;
         cc[j]   = lc[j].idle | lc[j].err;
         tv[j]   = lc[j].term;
         code[j] = lc[j].code;
         if (lc[j].term) t_lane = LIDX_W'(j);
      end
      lo_mask = tv - LANES'(1);
      hi_mask = ~(lo_mask | tv);
      all_dat = &dat;
      all_cc  = &cc;
      os0_ok  = lc[0].seq && (&dat[HALF-1:1]) && (&cc[LANES-1:HALF]);
      s0_ok   = lc[0].start && (&dat[LANES-1:1]);
      s4_ok   = (&cc[HALF-1:0]) && lc[HALF].start && (&dat[LANES-1:HALF+1]);
      t_ok    = $onehot(tv) && ((dat & lo_mask) == lo_mask)
                && ((cc & hi_mask) == hi_mask);
   end

   always_comb begin
      cls = BK_E;
      sh  = SH_CTRL;
      pay = '0;
      if (all_dat) begin
         cls = BK_D;
         sh  = SH_DATA;
         pay = data;
      end else if (all_cc) begin
         cls = BK_C;
         pay[CH_W-1:0] = BT_CTRL;
         for (int j = 0; j < LANES; j++)
            pay[CH_W + CODE_W*j +: CODE_W] = code[j];
      end else if (os0_ok) begin
         cls = BK_C;
         pay[CH_W-1:0] = BT_OS0;
         pay[CH_W +: (HALF-1)*CH_W] = data[CH_W +: (HALF-1)*CH_W];
         for (int j = HALF; j < LANES; j++)
            pay[CH_W + CODE_W*j +: CODE_W] = code[j];
      end else if (s0_ok) begin
         cls = BK_S;
         pay = {data[DATA_W-1:CH_W], BT_S0};
      end else if (s4_ok) begin
         cls = BK_S;
         pay[CH_W-1:0] = BT_S4;
         for (int j = 0; j < HALF; j++)
            pay[CH_W + CODE_W*j +: CODE_W] = code[j];
         pay[DATA_W-1:(HALF+1)*CH_W] = data[DATA_W-1:(HALF+1)*CH_W];
      end else if (t_ok) begin
         cls = BK_T;
         pay[CH_W-1:0] = term_type(t_lane);
         for (int j = 0; j < LANES-1; j++)
            if (j < int'(t_lane))
               pay[CH_W*(j+1) +: CH_W] = data[CH_W*j +: CH_W];
         for (int j = 1; j < LANES; j++)
            if (j > int'(t_lane))
               pay[CH_W + CODE_W*j +: CODE_W] = code[j];
      end
   end

endmodule

// File: rtl/enc66_tx_fsm.sv
module enc66_tx_fsm
   import enc66_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv,
   input  blk_cls_e cls,
   output tx_st_e   st,
   output logic     to_err
);

   tx_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         TS_INIT, TS_CTRL, TS_TERM: begin
            case (cls)
               BK_C:    st_d = TS_CTRL;
               BK_S:    st_d = TS_START;
               default: st_d = TS_ERR;
            endcase
         end
         TS_START, TS_DATA: begin
            case (cls)
               BK_D:    st_d = TS_DATA;
               BK_T:    st_d = TS_TERM;
               default: st_d = TS_ERR;
            endcase
         end
         default: begin
            case (cls)
               BK_C:    st_d = TS_CTRL;
               BK_D:    st_d = TS_DATA;
               BK_T:    st_d = TS_TERM;
               default: st_d = TS_ERR;
            endcase
         end
      endcase
   end

   assign to_err = (st_d == TS_ERR);
   assign st     = st_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   st_q <= TS_INIT;
      else if (adv) st_q <= st_d;
   end

endmodule

// File: rtl/enc66_tx_encoder.sv
module enc66_tx_encoder
   import enc66_pkg::*;
#(
   parameter int unsigned LANES      = 8,
   parameter int unsigned CH_W       = 8,
   parameter int unsigned SH_W       = 2,
   parameter bit          HDR_AT_LSB = 1'b1
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_vld,
   input  logic [LANES*CH_W-1:0]        in_data,
   input  logic [LANES-1:0]             in_ctl,
   output logic                         out_vld,
   output logic [LANES*CH_W+SH_W-1:0]   out_blk
);

   localparam int unsigned DATA_W = LANES * CH_W;
   localparam int unsigned BLK_W  = DATA_W + SH_W;
   localparam logic [BLK_W-1:0] LF_BLK = pack_blk(SH_CTRL, lf_payload(), HDR_AT_LSB);

   if (LANES != 8 || CH_W != 8 || SH_W != 2) begin : g_bad_cfg
      $error("enc66_tx_encoder: needs 8 lanes of 8 bits and a 2-bit header");
   end

   lane_cls_t [LANES-1:0] lc;
   blk_cls_e              cls;
   logic [1:0]            sh_raw, sh_sel;
   logic [DATA_W-1:0]     pay_raw, pay_sel;
   logic [BLK_W-1:0]      nxt_blk;
   logic                  to_err;
   tx_st_e                fsm_st;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      enc66_lane_cls #(.CH_W(CH_W)) u_lane (
         .ch  (in_data[g*CH_W +: CH_W]),
         .ctl (in_ctl[g]),
         .cls (lc[g])
      );
   end

   enc66_blk_build #(.LANES(LANES), .CH_W(CH_W)) u_build (
      .lc   (lc),
      .data (in_data),
      .cls  (cls),
      .sh   (sh_raw),
      .pay  (pay_raw)
   );

   enc66_tx_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (in_vld),
      .cls    (cls),
      .st     (fsm_st),
      .to_err (to_err)
   );

   assign sh_sel  = to_err ? SH_CTRL : sh_raw;
   assign pay_sel = to_err ? err_payload() : pay_raw;

   if (HDR_AT_LSB) begin : g_hdr_low
      assign nxt_blk = {pay_sel, sh_sel};
   end else begin : g_hdr_high
      assign nxt_blk = {sh_sel, pay_sel};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b1;
         out_blk <= LF_BLK;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_blk <= nxt_blk;
      end
   end

endmodule

// File: rtl/enc66_tx_chk.sv
module enc66_tx_chk
   import enc66_pkg::*;
#(
   parameter bit          HDR_AT_LSB = 1'b1,
   parameter int unsigned BLK_W      = 66
)(
   input logic             clk,
   input logic             rst_n,
   input logic             in_vld,
   input logic [63:0]      in_data,
   input logic [7:0]       in_ctl,
   input logic             out_vld,
   input logic [BLK_W-1:0] out_blk,
   input tx_st_e           st
);

   localparam logic [BLK_W-1:0] LF_B  = pack_blk(SH_CTRL, lf_payload(), HDR_AT_LSB);
   localparam logic [BLK_W-1:0] ERR_B = pack_blk(SH_CTRL, err_payload(), HDR_AT_LSB);

   logic [1:0] sh;
   assign sh = HDR_AT_LSB ? out_blk[1:0] : out_blk[BLK_W-1 -: 2];

   // R2
   hdr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (sh == SH_DATA || sh == SH_CTRL));

   // R7
   rst_fault_chk: assert property (@(posedge clk)
      !rst_n |=> (out_vld && out_blk == LF_B));

   // R9
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && $stable(out_blk)));

   // R1
   data_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && sh == SH_DATA) |-> ($past(in_ctl) == 8'h00));

   // R8
   ctrl_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_CTRL && in_vld && in_ctl == 8'h00) |=> (out_blk == ERR_B));

   // R8
   data_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == TS_DATA || st == TS_START) && in_vld && in_ctl == 8'hFF
       && in_data == {8{K_IDLE}}) |=> (out_blk == ERR_B));

   // R10
   err_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_ERR && in_vld && in_ctl == 8'h00) |=> (sh == SH_DATA));

endmodule

bind enc66_tx_encoder enc66_tx_chk #(.HDR_AT_LSB(HDR_AT_LSB), .BLK_W(BLK_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .in_data (in_data),
   .in_ctl  (in_ctl),
   .out_vld (out_vld),
   .out_blk (out_blk),
   .st      (fsm_st)
);

// File: tb/tb_enc66_tx_encoder.sv
`timescale 1ns/1ps
module tb_enc66_tx_encoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [63:0] in_data = '0;
   logic [7:0]  in_ctl = '0;
   logic        out_vld;
   logic [65:0] out_blk;

   int n_run = 0;
   int n_fail = 0;
   int ms = 0;               // 0 init 1 ctrl 2 start 3 data 4 term 5 err
   logic [65:0] exp_blk;
   logic        exp_vld;

   localparam logic [65:0] LF_EXP  = {32'h0, 8'h01, 8'h00, 8'h00, 8'h4B, 2'b10};
   localparam logic [65:0] ERR_EXP = {{8{7'h1E}}, 8'h1E, 2'b10};

   always #5 clk = ~clk;

   enc66_tx_encoder dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
      .in_ctl(in_ctl), .out_vld(out_vld), .out_blk(out_blk)
   );

   task automatic chk(input bit ok, input string req, input logic [65:0] act,
                      input logic [65:0] expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [7:0] byt(input logic [63:0] d, input int j);
      return d[8*j +: 8];
   endfunction

   function automatic bit ccl(input logic [63:0] d, input logic [7:0] c, input int j);
      return c[j] && (byt(d, j) == 8'h07 || byt(d, j) == 8'hFE);
   endfunction

   function automatic logic [6:0] c7(input logic [63:0] d, input int j);
      return (byt(d, j) == 8'hFE) ? 7'h1E : 7'h00;
   endfunction

   function automatic logic [7:0] ttype(input int k);
      case (k)
         0: return 8'h87; 1: return 8'h99; 2: return 8'hAA; 3: return 8'hB4;
         4: return 8'hCC; 5: return 8'hD2; 6: return 8'hE1; default: return 8'hFF;
      endcase
   endfunction

   // cls: 0 control 1 start 2 data 3 terminate 4 invalid 5 ordered set
   function automatic void model(input logic [63:0] d, input logic [7:0] c,
                                 output int cls, output logic [65:0] blk);
      logic [63:0] p;
      bit ok;
      p = '0; cls = 4; blk = ERR_EXP;
      if (c == 8'h00) begin cls = 2; blk = {d, 2'b01}; return; end
      ok = 1;
      for (int j = 0; j < 8; j++) if (!ccl(d, c, j)) ok = 0;
      if (ok) begin
         p[7:0] = 8'h1E;
         for (int j = 0; j < 8; j++) p[8+7*j +: 7] = c7(d, j);
         cls = 0; blk = {p, 2'b10}; return;
      end
      if (c[0] && byt(d, 0) == 8'h9C && c[3:1] == 3'b000) begin
         ok = 1;
         for (int j = 4; j < 8; j++) if (!ccl(d, c, j)) ok = 0;
         if (ok) begin
            p[7:0] = 8'h4B; p[31:8] = d[31:8];
            for (int j = 4; j < 8; j++) p[8+7*j +: 7] = c7(d, j);
            cls = 5; blk = {p, 2'b10}; return;
         end
      end
      if (c == 8'h01 && byt(d, 0) == 8'hFB) begin
         cls = 1; blk = {d[63:8], 8'h78, 2'b10}; return;
      end
      if (c == 8'h1F && byt(d, 4) == 8'hFB) begin
         ok = 1;
         for (int j = 0; j < 4; j++) if (!ccl(d, c, j)) ok = 0;
         if (ok) begin
            p[7:0] = 8'h33;
            for (int j = 0; j < 4; j++) p[8+7*j +: 7] = c7(d, j);
            p[63:40] = d[63:40];
            cls = 1; blk = {p, 2'b10}; return;
         end
      end
      for (int k = 0; k < 8; k++) begin
         if (c[k] && byt(d, k) == 8'hFD) begin
            ok = 1;
            for (int j = 0; j < k; j++) if (c[j]) ok = 0;
            for (int j = k + 1; j < 8; j++) if (!ccl(d, c, j)) ok = 0;
            if (ok) begin
               p[7:0] = ttype(k);
               for (int j = 0; j < k; j++) p[8+8*j +: 8] = byt(d, j);
               for (int j = k + 1; j < 8; j++) p[8+7*j +: 7] = c7(d, j);
               cls = 3; blk = {p, 2'b10};
            end
            return;
         end
      end
   endfunction

   function automatic int nxt(input int s, input int cls);
      int c;
      c = (cls == 5) ? 0 : cls;
      if (s == 0 || s == 1 || s == 4) return (c == 0) ? 1 : (c == 1) ? 2 : 5;
      if (s == 2 || s == 3)           return (c == 2) ? 3 : (c == 3) ? 4 : 5;
      return (c == 0) ? 1 : (c == 2) ? 3 : (c == 3) ? 4 : 5;
   endfunction

   // word generator: 0 idle 1 data 2 start0 3 start4 4 term k 5 ordered set
   // 6 random junk 7 idle/error mix
   task automatic gen(input int kind, input int k, output logic [63:0] d,
                      output logic [7:0] c);
      d = {$urandom, $urandom};
      c = 8'h00;
      case (kind)
         0: begin d = {8{8'h07}}; c = 8'hFF; end
         1: c = 8'h00;
         2: begin d[7:0] = 8'hFB; c = 8'h01; end
         3: begin d[39:0] = {8'hFB, {4{8'h07}}}; c = 8'h1F; end
         4: begin
            for (int j = k; j < 8; j++) d[8*j +: 8] = (j == k) ? 8'hFD : 8'h07;
            c = 8'hFF << k;
         end
         5: begin d[63:32] = {4{8'h07}}; d[7:0] = 8'h9C; c = 8'hF1; end
         7: begin
            for (int j = 0; j < 8; j++) d[8*j +: 8] = ($urandom % 2) ? 8'hFE : 8'h07;
            c = 8'hFF;
         end
         default: begin
            c = 8'($urandom);
            for (int j = 0; j < 8; j++)
               if (c[j])
                  case ($urandom % 6)
                     0: d[8*j +: 8] = 8'h07; 1: d[8*j +: 8] = 8'hFB;
                     2: d[8*j +: 8] = 8'hFD; 3: d[8*j +: 8] = 8'hFE;
                     4: d[8*j +: 8] = 8'h9C; default: ;
                  endcase
         end
      endcase
   endtask

   task automatic step(input logic v, input logic [63:0] d, input logic [7:0] c,
                       input string req);
      int cls, ns;
      logic [65:0] b;
      string tag;
      in_vld = v; in_data = d; in_ctl = c;
      tag = req;
      if (v) begin
         model(d, c, cls, b);
         ns = nxt(ms, cls);
         exp_blk = (ns == 5) ? ERR_EXP : b;
         exp_vld = 1'b1;
         if (tag == "") begin
            if (ns == 5)       tag = "R8";
            else if (ms == 5)  tag = "R10";
            else case (cls)
               0: tag = "R3 R2"; 1: tag = "R4 R2"; 2: tag = "R1";
               3: tag = "R5 R2"; default: tag = "R6 R2";
            endcase
         end
         ms = ns;
      end else begin
         exp_vld = 1'b0;
         if (tag == "") tag = "R9";
      end
      @(negedge clk);
      chk(out_vld == exp_vld && out_blk == exp_blk, tag,
          {out_vld, out_blk[64:0]}, {exp_vld, exp_blk[64:0]});
   endtask

   task automatic do_reset(input int n);
      rst_n = 1'b0;
      for (int i = 0; i < n; i++) begin
         in_vld = i[0]; in_data = {$urandom, $urandom}; in_ctl = 8'($urandom);
         @(negedge clk);
         chk(out_vld && out_blk == LF_EXP, "R7", out_blk, LF_EXP);
      end
      rst_n = 1'b1;
      ms = 0;
      exp_blk = LF_EXP;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] d;
      logic [7:0]  c;
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset(4);

      // directed sequencing and layouts
      gen(1, 0, d, c); step(1, d, c, "R8");        // data straight after reset
      gen(0, 0, d, c); step(1, d, c, "R10 R3");    // error -> control
      gen(1, 0, d, c); step(1, d, c, "R8");        // control -> data illegal
      gen(1, 0, d, c); step(1, d, c, "R10 R1");    // error -> data
      gen(4, 3, d, c); step(1, d, c, "R5");
      gen(2, 0, d, c); step(1, d, c, "R4");
      gen(1, 0, d, c); step(1, d, c, "R1");
      gen(0, 0, d, c); step(1, d, c, "R8");        // data -> idle illegal
      gen(2, 0, d, c); step(1, d, c, "R10 R8");    // start after error stays error
      gen(7, 0, d, c); step(1, d, c, "R10 R3");
      gen(5, 0, d, c); d[31:8] = 24'h010000; step(1, d, c, "R6");
      gen(3, 0, d, c); d[15:8] = 8'hFE; step(1, d, c, "R4");
      gen(1, 0, d, c); step(1, d, c, "R1");
      for (int k = 0; k < 8; k++) begin
         gen(2, 0, d, c); step(1, d, c, "R4");
         gen(4, k, d, c); d[63:56] = (k < 7) ? 8'hFE : d[63:56];
         step(1, d, c, "R5");
      end
      gen(4, 2, d, c); step(1, d, c, "R8");        // terminate without start
      gen(4, 5, d, c); step(1, d, c, "R10 R5");    // error -> terminate
      gen(6, 0, d, c); step(1'b0, d, c, "R9");
      gen(1, 0, d, c); step(1'b0, d, c, "R9");     // state must still be terminate
      gen(2, 0, d, c); step(1, d, c, "R9 R4");
      gen(2, 0, d, c); step(1, d, c, "R8");        // start inside a frame
      do_reset(3);

      // constrained random frames with injected faults
      for (int i = 0; i < 4000; i++) begin
         int r, kind;
         logic v;
         r = int'($urandom % 100);
         v = (($urandom % 10) != 0);
         if (ms == 2 || ms == 3)
            kind = (r < 70) ? 1 : (r < 92) ? 4 : (r < 96) ? 0 : 6;
         else
            kind = (r < 40) ? 0 : (r < 50) ? 5 : (r < 58) ? 7 :
                   (r < 90) ? ((r % 2 == 1) ? 2 : 3) : (r < 95) ? 1 : 6;
         gen(kind, int'($urandom % 8), d, c);
         step(v, d, c, "");
         if (i == 2000) do_reset(2);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule